// File: doc/BRIEF.md
# Dual-Channel DMA Request Handshake

This block sits between an external DMA controller and a pair of sample FIFOs. It watches each FIFO's fill flags and drives a request line that asks the DMA controller for a transfer. When the controller answers with an acknowledge and an active-low read or write strobe, the block turns the end of each strobe into a single-cycle pop or push pulse for the FIFO, in the system clock domain. Strobes and acknowledges arrive asynchronously and are brought in through two-flop synchronizers.

In the default arrangement one request/acknowledge pair serves the left FIFO. When DMA, stereo and playback are all selected, a second pair serves the right FIFO. This pair reuses two multi-purpose pins: the full-flag output becomes the right request and the channel-select input becomes the right acknowledge. The active level of every request and acknowledge pin can be set by configuration inputs.

Top module: `dma_req_ctrl`

## Requirements
- R1: In playback (recording=0) with dma_en=1, the left request sets when l_half=0, clears when l_full=1, and otherwise holds its state. Clearing wins over setting.
- R2: In recording (recording=1) with dma_en=1, the left request sets when l_half=1, clears when l_empty=1, and otherwise holds. The request state updates on the clock edge after the flags change.
- R3: A request pin is high when its request is active if its polarity input (pol_req_l or pol_req_r) is 0, and low when active if that input is 1. When the request is inactive the pin shows the opposite level.
- R4: The left acknowledge is active when ack_l_pin is low if pol_ack_l=0, and when it is high if pol_ack_l=1. The right acknowledge follows pol_ack_r in the same way.
- R5: Each io_wr_n low pulse that ends (rising edge) while the left acknowledge is active gives exactly one push_l pulse. Each such io_rd_n pulse gives exactly one pop_l pulse.
- R6: A strobe that ends while no acknowledge is active gives no pulse.
- R7: Dual mode is dma_en=1, stereo=1 and recording=0. In dual mode flag_req_pin carries the right request, which follows the R1 rules on r_half and r_full. Outside dual mode the right request is held inactive.
- R8: In dual mode chsel_ack_pin is the right acknowledge. A write strobe accepted under it gives one push_r pulse, and a read strobe under it alone gives no pulse.
- R9: When both acknowledges are active, a write strobe goes to the left FIFO only (push_l), and push_r stays low.
- R10: With dma_en=0 both requests are inactive, and strobes give no pulses whatever the acknowledge levels.
- R11: Outside dual mode flag_req_pin shows a full flag, active high. It is r_full when stereo=1 and chsel_ack_pin=1, and l_full otherwise.
- R12: Each pulse lasts one clock cycle. It appears between 2 and 4 clock edges after the strobe's rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_en | input | 1 | DMA transfers enabled |
| stereo | input | 1 | Stereo operation selected |
| recording | input | 1 | 1 = recording, 0 = playback |
| pol_req_l | input | 1 | 1 = left request pin active low |
| pol_req_r | input | 1 | 1 = right request pin active low |
| pol_ack_l | input | 1 | 1 = left acknowledge active high |
| pol_ack_r | input | 1 | 1 = right acknowledge active high |
| l_empty | input | 1 | Left FIFO empty |
| l_half | input | 1 | Left FIFO at least half full |
| l_full | input | 1 | Left FIFO full |
| r_empty | input | 1 | Right FIFO empty |
| r_half | input | 1 | Right FIFO at least half full |
| r_full | input | 1 | Right FIFO full |
| ack_l_pin | input | 1 | Left DMA acknowledge pin |
| chsel_ack_pin | input | 1 | Channel select, or right acknowledge in dual mode |
| io_wr_n | input | 1 | DMA write strobe, active low |
| io_rd_n | input | 1 | DMA read strobe, active low |
| req_l_pin | output | 1 | Left DMA request pin |
| flag_req_pin | output | 1 | Full flag, or right request in dual mode |
| push_l | output | 1 | Push pulse to the left FIFO |
| pop_l | output | 1 | Pop pulse from the left FIFO |
| push_r | output | 1 | Push pulse to the right FIFO |

## Verification
Two things can coincide in one cycle. The left and right acknowledges can both be active when a write strobe ends, and the left acknowledge qualification can overlap the right acknowledge path. The bench provokes this by holding both acknowledge pins active across a write pulse in dual mode. It judges the result through the scoreboard: exactly one push_l is expected, and any push_r pulse, or a push_l arriving together with push_r, is a mismatch. A read strobe under the right acknowledge alone, and strobes under swapped polarity settings, are also run to show that the priority and acceptance logic keys on the active level and not on the raw pin.

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic stereo,
  input  logic recording,
  input  logic pol_req_l,
  input  logic pol_req_r,
  input  logic pol_ack_l,
  input  logic pol_ack_r,
  input  logic l_empty,
  input  logic l_half,
  input  logic l_full,
  input  logic r_empty,
  input  logic r_half,
  input  logic r_full,
  input  logic ack_l_pin,
  input  logic chsel_ack_pin,
  input  logic io_wr_n,
  input  logic io_rd_n,
  output logic req_l_pin,
  output logic flag_req_pin,
  output logic push_l,
  output logic pop_l,
  output logic push_r
);

  logic dual;
  logic req_l, req_r;
  logic set_l, clr_l, set_r, clr_r;
  logic [2:0] wr_s, rd_s, al_s, ar_s;
  logic wr_rise, rd_rise, al_act, ar_act;

  assign dual  = dma_en & stereo & ~recording;

  assign set_l = recording ? l_half  : ~l_half;
  assign clr_l = recording ? l_empty : l_full;
  assign set_r = ~r_half;
  assign clr_r = r_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_l <= 1'b0;
      req_r <= 1'b0;
    end else begin
      req_l <= dma_en & ~clr_l & (set_l | req_l);
      req_r <= dual & ~clr_r & (set_r | req_r);
    end
  end

  assign req_l_pin    = req_l ^ pol_req_l;
  assign flag_req_pin = dual ? (req_r ^ pol_req_r)
                             : ((stereo & chsel_ack_pin) ? r_full : l_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_s <= 3'b111;
      rd_s <= 3'b111;
      al_s <= 3'b111;
      ar_s <= 3'b111;
    end else begin
      wr_s <= {wr_s[1:0], io_wr_n};
      rd_s <= {rd_s[1:0], io_rd_n};
      al_s <= {al_s[1:0], ack_l_pin};
      ar_s <= {ar_s[1:0], chsel_ack_pin};
    end
  end

  assign wr_rise = wr_s[1] & ~wr_s[2];
  assign rd_rise = rd_s[1] & ~rd_s[2];
  assign al_act  = ~(al_s[2] ^ pol_ack_l);
  assign ar_act  = dual & ~(ar_s[2] ^ pol_ack_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_l <= 1'b0;
      pop_l  <= 1'b0;
      push_r <= 1'b0;
    end else begin
      push_l <= dma_en & al_act & wr_rise;
      pop_l  <= dma_en & al_act & rd_rise;
      push_r <= dma_en & ~al_act & ar_act & wr_rise;
    end
  end

  assert_play_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && !recording && l_full) |=> !req_l);
  assert_rec_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && recording && l_empty) |=> !req_l);
  assert_right_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_en && stereo && !recording) |=> !req_r);
  assert_left_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_l && push_r));
  assert_dma_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> (!req_l && !req_r && !push_l && !pop_l && !push_r));
  assert_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (push_l || pop_l || push_r) |=> !(push_l || pop_l || push_r));

endmodule

// File: tb/dma_req_ctrl_test.sv
module dma_req_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic dma_en = 0, stereo = 0, recording = 0;
  logic pol_req_l = 0, pol_req_r = 0, pol_ack_l = 0, pol_ack_r = 0;
  logic l_empty = 1, l_half = 0, l_full = 0, r_empty = 1, r_half = 0, r_full = 0;
  logic ack_l_pin = 1, chsel_ack_pin = 1, io_wr_n = 1, io_rd_n = 1;
  logic req_l_pin, flag_req_pin, push_l, pop_l, push_r;
  int total = 0, bad = 0;
  logic [2:0] expq[$];
  string tagq[$];

  always #2.5 clk = ~clk;

  dma_req_ctrl uut (.*);

  // code: bit0 push_l, bit1 pop_l, bit2 push_r
  always @(negedge clk) if (rst_n && (push_l || pop_l || push_r)) begin
    logic [2:0] got;
    got = {push_r, pop_l, push_l};
    total++;
    if (expq.size() == 0) begin
      bad++;
      $display("FAIL unexpected pulse: got=%b expected=none", got);
    end else begin
      logic [2:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      if (got !== e) begin
        bad++;
        $display("FAIL %s pulse: got=%b expected=%b", t, got, e);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic strobe(string tag, bit wr, logic [2:0] exp);
    if (exp != 0) begin
      expq.push_back(exp);
      tagq.push_back(tag);
    end
    if (wr) io_wr_n = 0; else io_rd_n = 0;
    cyc(3);
    io_wr_n = 1;
    io_rd_n = 1;
    cyc(8);
    total++;
    if (expq.size() != 0) begin
      bad++;
      $display("FAIL %s missing pulse: got=none expected=%b", tag, expq[0]);
      expq.delete();
      tagq.delete();
    end
  endtask

  initial begin
    cyc(3);
    chk("reset R10 req", req_l_pin, 1'b0);
    chk("reset R12 push", push_l, 1'b0);
    rst_n = 1;
    cyc(2);
    // R10: dma off
    ack_l_pin = 0;
    strobe("R10 off write", 1, 3'b000);
    chk("R10 req_l idle", req_l_pin, 1'b0);
    ack_l_pin = 1;
    // R1 playback
    dma_en = 1; l_empty = 0; l_half = 0; l_full = 0;
    cyc(2); chk("R1 set not half", req_l_pin, 1'b1);
    l_half = 1; cyc(2); chk("R1 hold at half", req_l_pin, 1'b1);
    l_full = 1; cyc(2); chk("R1 clear full", req_l_pin, 1'b0);
    l_full = 0; cyc(2); chk("R1 stay clear", req_l_pin, 1'b0);
    l_half = 0; cyc(2); chk("R1 reset again", req_l_pin, 1'b1);
    // R3
    pol_req_l = 1; cyc(1); chk("R3 inverted active", req_l_pin, 1'b0);
    pol_req_l = 0;
    // R2 recording
    recording = 1; l_half = 0; l_empty = 0;
    cyc(2); chk("R2 holds", req_l_pin, 1'b1);
    l_empty = 1; cyc(2); chk("R2 clear empty", req_l_pin, 1'b0);
    l_empty = 0; cyc(2); chk("R2 stay clear", req_l_pin, 1'b0);
    l_half = 1; cyc(2); chk("R2 set half", req_l_pin, 1'b1);
    // R11
    chk("R11 left full", flag_req_pin, 1'b0);
    l_full = 1; cyc(1); chk("R11 left full set", flag_req_pin, 1'b1);
    stereo = 1; r_full = 0; chsel_ack_pin = 1; cyc(1);
    chk("R11 right selected", flag_req_pin, 1'b0);
    chsel_ack_pin = 0; cyc(1); chk("R11 left selected", flag_req_pin, 1'b1);
    l_full = 0; chsel_ack_pin = 1; stereo = 0; recording = 0; l_half = 1;
    // R5, R6
    ack_l_pin = 0; cyc(4);
    strobe("R5 write", 1, 3'b001);
    strobe("R5 read", 0, 3'b010);
    strobe("R5 second write", 1, 3'b001);
    ack_l_pin = 1; cyc(4);
    strobe("R6 no ack write", 1, 3'b000);
    strobe("R6 no ack read", 0, 3'b000);
    // R4
    pol_ack_l = 1; ack_l_pin = 1; cyc(4);
    strobe("R4 high ack write", 1, 3'b001);
    ack_l_pin = 0; cyc(4);
    strobe("R4 low ignored", 1, 3'b000);
    pol_ack_l = 0; ack_l_pin = 1;
    // R7 dual request
    stereo = 1; r_half = 0; r_full = 0; r_empty = 0; chsel_ack_pin = 1;
    cyc(2); chk("R7 right req set", flag_req_pin, 1'b1);
    pol_req_r = 1; cyc(1); chk("R7 R3 right inverted", flag_req_pin, 1'b0);
    pol_req_r = 0;
    r_full = 1; r_half = 1; cyc(2); chk("R7 right req clear", flag_req_pin, 1'b0);
    r_full = 0; r_half = 0; cyc(2); chk("R7 right req again", flag_req_pin, 1'b1);
    // R8
    chsel_ack_pin = 0; cyc(4);
    strobe("R8 right write", 1, 3'b100);
    strobe("R8 right read ignored", 0, 3'b000);
    pol_ack_r = 1; chsel_ack_pin = 1; cyc(4);
    strobe("R8 R4 right high ack", 1, 3'b100);
    pol_ack_r = 0;
    // R9
    chsel_ack_pin = 0; ack_l_pin = 0; cyc(4);
    strobe("R9 both acks", 1, 3'b001);
    ack_l_pin = 1; chsel_ack_pin = 1;
    // R7 right off when mode leaves dual
    recording = 1; cyc(2);
    chk("R7 right off in record", flag_req_pin, r_full);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R12: got=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule